// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block watches a packed-BCD calendar supplied by a neighbouring timekeeping counter and raises an alarm when the live date and time reach a programmed moment. Software programs six alarm bytes through a small byte-wide register port: seconds, minutes, hours, day of month, month and year. The day of the week takes no part in the match. The comparison is made only on the cycle in which the counter reports a seconds increment, so a given alarm moment can fire at most once.

A match sets two sticky flags. The first is an alarm status flag, which drives the interrupt line only while the alarm enable bit is also 1. The second is a wake-cause flag, which is set whatever the enable holds, so software can learn after a wake-up that the alarm fired. Each flag is cleared by writing 1 to its bit. The expected programming sequence is: clear the enable, rewrite the alarm bytes, then set the enable again. A match that lands while the enable is 0 still records status but leaves the interrupt line low.

Top module: `bcd_alarm_unit`

## Requirements
- R1: Addresses 0 to 5 hold the alarm bytes for seconds, minutes, hours, day, month (BCD 01 to 12) and year (BCD years after 2000), in that order. Each byte is written through the port and reads back unchanged at the same address, and each resets to 0x00.
- R2: Address 6 bit 0 is the alarm enable, address 7 bit 0 is the alarm status and address 8 bit 0 is the wake cause. All other bits of these three registers read 0. Unmapped addresses read 0x00, and writes to them change nothing.
- R3: When `sec_tick` is 1 in a cycle and every live field equals its alarm byte, `alarm_flag` is 1 from the next cycle. Equal fields with `sec_tick` at 0 set nothing.
- R4: A difference in any one of the six fields, month and year included, prevents the flag from being set.
- R5: `alarm_flag` stays 1 until a write to address 7 with bit 0 set, which clears it in the next cycle. A write with bit 0 clear has no effect. If a clearing write and a match fall in the same cycle, the flag ends up set.
- R6: `alarm_irq` is high exactly while the status flag and the enable bit are both 1, and it follows them in the same cycle.
- R7: A match taken while the enable is 0 sets `alarm_flag` but keeps `alarm_irq` low. Setting the enable afterwards raises `alarm_irq`.
- R8: Every match also sets `wake_flag`, whatever the enable holds. A write to address 8 with bit 0 set clears it, and this clear is independent of the status clear. If the clearing write and a match fall in the same cycle, the wake flag ends up set.
- R9: During reset the enable, both flags and `alarm_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse when the calendar seconds advance |
| live_time | input | NUM_FIELDS*FIELD_W (48) | Live BCD calendar; field i is at bits [8i+7:8i], seconds lowest, year highest |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address for reads and writes |
| reg_wdata | input | FIELD_W (8) | Register write data |
| reg_rdata | output | FIELD_W (8) | Read data for `reg_addr`, combinational |
| alarm_flag | output | 1 | Sticky alarm status |
| wake_flag | output | 1 | Sticky wake-cause flag |
| alarm_irq | output | 1 | Level interrupt, status and enable both 1 |

## Verification
The assertions assume that `sec_tick` and the register strobe are sampled on the same clock edge as the flags, and that the register port inputs are 0 while reset is held, because some checks look one cycle back across reset release. The stimulus drives every input a quarter period after the rising edge and holds it for a full cycle. The port stays idle during reset. In the random phase, the live time is built from the programmed alarm bytes with at most one field altered, so matches, near misses, clears and enable changes keep colliding in the same cycles.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
   // bit positions inside the control / status / wake registers
   localparam int unsigned ENABLE_BIT = 0;
   localparam int unsigned STATUS_BIT = 0;
   localparam int unsigned WAKE_BIT   = 0;

   // number of non-alarm registers placed after the alarm bytes
   localparam int unsigned EXTRA_REGS = 3;

   // decoded write strobes from the register port
   typedef struct packed {
      logic ctrl_wr;
      logic ctrl_val;
      logic stat_clr;
      logic wake_clr;
   } flag_strobe_t;
endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs #(
   parameter int unsigned NUM_FIELDS = 6,
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned ADDR_W     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [FIELD_W-1:0]            wdata,
   output logic [NUM_FIELDS*FIELD_W-1:0] alarm_vec
);
   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
      logic [FIELD_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (wr && (addr == MY_ADDR)) begin
            byte_q <= wdata;
         end
      end
      assign alarm_vec[g*FIELD_W +: FIELD_W] = byte_q;
   end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match #(
   parameter int unsigned NUM_FIELDS = 6,
   parameter int unsigned FIELD_W    = 8
) (
   input  logic                          tick,
   input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_vec,
   input  logic [NUM_FIELDS*FIELD_W-1:0] live_vec,
   output logic                          hit
);
   logic [NUM_FIELDS-1:0] field_eq;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
      assign field_eq[g] = (alarm_vec[g*FIELD_W +: FIELD_W] == live_vec[g*FIELD_W +: FIELD_W]);
   end

   assign hit = tick && (&field_eq);
endmodule

// File: rtl/bcd_alarm_flags.sv
module bcd_alarm_flags
   import bcd_alarm_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   input  flag_strobe_t strb,
   output logic         enable,
   output logic         status,
   output logic         wake,
   output logic         irq
);
   logic enable_d, status_d, wake_d;

   always_comb begin
      enable_d = strb.ctrl_wr ? strb.ctrl_val : enable;
      // a match in the same cycle as a clear wins
      status_d = hit ? 1'b1 : (strb.stat_clr ? 1'b0 : status);
      wake_d   = hit ? 1'b1 : (strb.wake_clr ? 1'b0 : wake);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         status <= 1'b0;
         wake   <= 1'b0;
      end else begin
         enable <= enable_d;
         status <= status_d;
         wake   <= wake_d;
      end
   end

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= status_d && enable_d;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = status && enable;
   end
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
   import bcd_alarm_pkg::*;
#(
   parameter int unsigned NUM_FIELDS = 6,
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          IRQ_REG    = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sec_tick,
   input  logic [NUM_FIELDS*FIELD_W-1:0] live_time,
   input  logic                          reg_wr,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [FIELD_W-1:0]            reg_wdata,
   output logic [FIELD_W-1:0]            reg_rdata,
   output logic                          alarm_flag,
   output logic                          wake_flag,
   output logic                          alarm_irq
);
   localparam int unsigned        REG_COUNT = NUM_FIELDS + EXTRA_REGS;
   localparam logic [ADDR_W-1:0]  CTRL_ADDR = ADDR_W'(NUM_FIELDS);
   localparam logic [ADDR_W-1:0]  STAT_ADDR = ADDR_W'(NUM_FIELDS + 1);
   localparam logic [ADDR_W-1:0]  WAKE_ADDR = ADDR_W'(NUM_FIELDS + 2);

   if (NUM_FIELDS < 1) begin : g_bad_fields
      $error("bcd_alarm_unit: NUM_FIELDS must be at least 1");
   end
   if (FIELD_W < 1) begin : g_bad_width
      $error("bcd_alarm_unit: FIELD_W must be at least 1");
   end
   if ((2 ** ADDR_W) < REG_COUNT) begin : g_bad_addr
      $error("bcd_alarm_unit: ADDR_W too narrow for the register map");
   end

   logic [NUM_FIELDS*FIELD_W-1:0] alarm_vec;
   logic                          hit;
   logic                          enable;
   flag_strobe_t                  strb;

   bcd_alarm_regs #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .alarm_vec(alarm_vec)
   );

   bcd_alarm_match #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)
   ) u_match (
      .tick(sec_tick), .alarm_vec(alarm_vec), .live_vec(live_time), .hit(hit)
   );

   always_comb begin
      strb.ctrl_wr  = reg_wr && (reg_addr == CTRL_ADDR);
      strb.ctrl_val = reg_wdata[ENABLE_BIT];
      strb.stat_clr = reg_wr && (reg_addr == STAT_ADDR) && reg_wdata[STATUS_BIT];
      strb.wake_clr = reg_wr && (reg_addr == WAKE_ADDR) && reg_wdata[WAKE_BIT];
   end

   bcd_alarm_flags #(.IRQ_REG(IRQ_REG)) u_flags (
      .clk(clk), .rst_n(rst_n), .hit(hit), .strb(strb),
      .enable(enable), .status(alarm_flag), .wake(wake_flag), .irq(alarm_irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (reg_addr == ADDR_W'(i)) reg_rdata = alarm_vec[i*FIELD_W +: FIELD_W];
      end
      if (reg_addr == CTRL_ADDR) reg_rdata[ENABLE_BIT] = enable;
      if (reg_addr == STAT_ADDR) reg_rdata[STATUS_BIT] = alarm_flag;
      if (reg_addr == WAKE_ADDR) reg_rdata[WAKE_BIT]   = wake_flag;
   end
endmodule

// File: rtl/bcd_alarm_unit_chk.sv
module bcd_alarm_unit_chk #(
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_FIELDS = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sec_tick,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [FIELD_W-1:0] reg_wdata,
   input logic               alarm_flag,
   input logic               wake_flag,
   input logic               alarm_irq
);
   logic stat_clr_w, wake_clr_w;
   assign stat_clr_w = reg_wr && (reg_addr == ADDR_W'(NUM_FIELDS + 1)) && reg_wdata[0];
   assign wake_clr_w = reg_wr && (reg_addr == ADDR_W'(NUM_FIELDS + 2)) && reg_wdata[0];

   assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> alarm_flag);

   assert_flag_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(sec_tick));

   assert_wake_rise_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(sec_tick));

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(alarm_flag) && !$past(stat_clr_w)) |-> alarm_flag);

   assert_flag_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_clr_w) && !$past(sec_tick)) |-> !alarm_flag);

   assert_wake_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wake_clr_w) && !$past(sec_tick)) |-> !wake_flag);

   assert_wake_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wake_flag) && !$past(wake_clr_w)) |-> wake_flag);
endmodule

bind bcd_alarm_unit bcd_alarm_unit_chk #(
   .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .NUM_FIELDS(NUM_FIELDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .alarm_flag(alarm_flag),
   .wake_flag(wake_flag), .alarm_irq(alarm_irq)
);

// File: tb/bcd_alarm_unit_bench.sv
module bcd_alarm_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic [47:0] live_time = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        alarm_flag, wake_flag, alarm_irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   // behavioural reference state
   int m_alarm [NF] = '{0, 0, 0, 0, 0, 0};
   bit m_en = 0, m_st = 0, m_wk = 0;

   bcd_alarm_unit u_bcd_alarm_unit (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .live_time(live_time),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .alarm_flag(alarm_flag), .wake_flag(wake_flag),
      .alarm_irq(alarm_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model: updated on the same edge as the design
   always @(posedge clk) begin
      bit hit;
      if (!rst_n) begin
         for (int i = 0; i < NF; i++) m_alarm[i] = 0;
         m_en = 0; m_st = 0; m_wk = 0;
      end else begin
         hit = sec_tick;
         for (int i = 0; i < NF; i++)
            if (int'(live_time[i*8 +: 8]) != m_alarm[i]) hit = 0;
         if (hit) m_st = 1;
         else if (reg_wr && reg_addr == 7 && reg_wdata[0]) m_st = 0;
         if (hit) m_wk = 1;
         else if (reg_wr && reg_addr == 8 && reg_wdata[0]) m_wk = 0;
         if (reg_wr && reg_addr < NF) m_alarm[reg_addr] = int'(reg_wdata);
         if (reg_wr && reg_addr == 6) m_en = reg_wdata[0];
      end
   end

   function automatic int exp_rdata(input int a);
      if (a < NF)  return m_alarm[a];
      if (a == 6)  return int'(m_en);
      if (a == 7)  return int'(m_st);
      if (a == 8)  return int'(m_wk);
      return 0;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk("R9 alarm_flag in reset", int'(alarm_flag), 0);
            chk("R9 wake_flag in reset", int'(wake_flag), 0);
            chk("R9 alarm_irq in reset", int'(alarm_irq), 0);
         end else begin
            chk("R3 R4 R5 alarm_flag", int'(alarm_flag), int'(m_st));
            chk("R8 wake_flag", int'(wake_flag), int'(m_wk));
            chk("R6 R7 alarm_irq", int'(alarm_irq), int'(m_st & m_en));
            chk("R1 R2 reg_rdata", int'(reg_rdata), exp_rdata(int'(reg_addr)));
         end
      end
   end

   task automatic drive(input bit wr, input int a, input int d, input bit tk);
      @(posedge clk);
      #(CLK_PERIOD/4);
      reg_wr = wr; reg_addr = 4'(a); reg_wdata = 8'(d); sec_tick = tk;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, int'(reg_addr), 0, 0);
   endtask

   function automatic logic [47:0] alarm_time();
      logic [47:0] t;
      for (int i = 0; i < NF; i++) t[i*8 +: 8] = 8'(m_alarm[i]);
      return t;
   endfunction

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      mismatched++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [47:0] t;
      int vals [NF] = '{'h30, 'h45, 'h12, 'h15, 'h06, 'h24};
      repeat (4) @(posedge clk);
      #(CLK_PERIOD/4); rst_n = 1'b1;
      idle(1);
      // R1: program the alarm bytes then read every address back
      for (int i = 0; i < NF; i++) drive(1, i, vals[i], 0);
      for (int a = 0; a < 16; a++) drive(0, a, 0, 0);
      // R2: unmapped writes ignored
      for (int a = 9; a < 16; a++) drive(1, a, 'hFF, 0);
      for (int a = 0; a < 16; a++) drive(0, a, 0, 0);
      // enable
      drive(1, 6, 'hFF, 0);
      live_time = alarm_time();
      // R3: equal but no tick
      drive(0, 7, 0, 0); idle(2);
      // R4: each field different by one
      for (int f = 0; f < NF; f++) begin
         t = alarm_time(); t[f*8 +: 8] = t[f*8 +: 8] ^ 8'h01;
         live_time = t;
         drive(0, 7, 0, 1); idle(1);
      end
      // R3/R6: full match with tick
      live_time = alarm_time();
      drive(0, 7, 0, 1); idle(3);
      // R5: write bit0=0 has no effect, then clear
      drive(1, 7, 'hFE, 0); idle(1);
      drive(1, 7, 'h01, 0); drive(0, 8, 0, 0); idle(1);
      // R8: wake still set, clear it
      drive(1, 8, 'h01, 0); idle(1);
      // R7: match with enable low, then enable
      drive(1, 6, 0, 0);
      drive(0, 7, 0, 1); idle(2);
      drive(1, 6, 1, 0); idle(2);
      // R5/R8: clear in the same cycle as a match
      drive(1, 7, 1, 1); idle(1);
      drive(1, 8, 1, 1); idle(1);
      drive(1, 7, 1, 0); drive(1, 8, 1, 0); idle(1);
      // mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         t = alarm_time();
         if ($urandom_range(0, 2) != 0) begin
            int f = $urandom_range(0, NF - 1);
            t[f*8 +: 8] = 8'($urandom_range(0, 255));
         end
         live_time = t;
         drive(bit'($urandom_range(0, 3) == 0), $urandom_range(0, 15),
               $urandom_range(0, 255), bit'($urandom_range(0, 2) == 0));
      end
      idle(2);
      finish_run();
   end
endmodule